// File: doc/BRIEF.md
# Memory Error Log Queue

This block collects memory error reports from the memory subsystem into a first-in, first-out queue that software drains one entry at a time. Each report carries an error class, a corrected/uncorrected flag, a flag marking reports found outside a consuming access (scrubber reads, speculative reads that were never used), the physical address, and the bank and device numbers that identify the replaceable memory part. Every report is stored, corrected or not, so that no detected error goes unrecorded.

An uncorrected error that a consuming access hit produces a one-cycle synchronous fault pulse. An asynchronous or corrected report never produces that pulse; it is only logged. A level-sensitive interrupt asks software to drain the queue. It is raised when the queue reaches three quarters full, when any stored entry belongs to a class that software has marked severe, or when the oldest entry has waited longer than a programmable age. If the queue is full, further reports are dropped and a saturating counter records the loss.

Top module: `mem_err_log`

## Requirements
- R1: A report with `rpt_valid` high is stored when the queue is not full, whatever its corrected and asynchronous flags. `level` counts the stored entries. When `level` is nonzero, `head_valid` is 1 and the head outputs show the oldest entry's class, uncorrected flag, asynchronous flag, address, bank and device.
- R2: Entries leave in arrival order. A `pop` removes the head. A `pop` while the queue is empty has no effect on `level` or on the outputs.
- R3: `sync_fault` is 1 for exactly the cycle after a report with `rpt_uncorr`=1 and `rpt_async`=0. It stays 0 after any corrected or asynchronous report.
- R4: A report that arrives while `level` equals DEPTH without a `pop` is dropped, and the queue contents are left unchanged. `ovf_count` then increments by one and saturates at 2^OVF_W-1.
- R5: A report that arrives in the same cycle as a `pop` of a full queue is accepted. `level` stays at DEPTH and `ovf_count` does not change.
- R6: `irq` is 1 in the cycle after any cycle in which `level` >= (DEPTH*3)/4.
- R7: `irq` is 1 while any stored entry has a class whose bit in `cfg_severe_mask` (bit index = class value) was set when the entry was accepted. The flag is raised one cycle after the entry is accepted.
- R8: The head age is 0 in the first cycle an entry is visible at the head. It counts up by one each cycle while the queue is not empty, restarts when a pop exposes a new head, and stays at 0 while the queue is empty. `irq` is 1 in the cycle after the age reaches the limit.
- R9: When `cfg_age_limit` is 0, the age limit is the parameter AGE_DEFAULT.
- R10: `irq` is level-sensitive. It drops in the cycle after the first cycle in which no trigger condition holds.
- R11: After a synchronous reset, `level`, `ovf_count`, `irq`, `sync_fault` and `head_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rpt_valid | input | 1 | Error report present this cycle |
| rpt_class | input | CLASS_W | Error class of the report |
| rpt_uncorr | input | 1 | 1 = uncorrected error, 0 = corrected |
| rpt_async | input | 1 | 1 = found by a scrub or an unconsumed speculative read |
| rpt_addr | input | ADDR_W | Physical address of the error |
| rpt_bank | input | BANK_W | Bank number |
| rpt_dev | input | DEV_W | Device number |
| pop | input | 1 | Software removes the head entry |
| cfg_severe_mask | input | 2^CLASS_W | One bit per class; 1 marks the class as severe |
| cfg_age_limit | input | AGE_W | Age limit in cycles; 0 selects AGE_DEFAULT |
| irq | output | 1 | Level-sensitive interrupt request |
| sync_fault | output | 1 | Synchronous fault pulse for a consumed uncorrected error |
| ovf_count | output | OVF_W | Saturating count of dropped reports |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| head_valid | output | 1 | Head outputs hold an entry |
| head_class | output | CLASS_W | Class of the oldest entry |
| head_uncorr | output | 1 | Uncorrected flag of the oldest entry |
| head_async | output | 1 | Asynchronous flag of the oldest entry |
| head_addr | output | ADDR_W | Address of the oldest entry |
| head_bank | output | BANK_W | Bank of the oldest entry |
| head_dev | output | DEV_W | Device of the oldest entry |

## Verification
The bench builds the block with DEPTH=8, OVF_W=3 and AGE_DEFAULT=40. With these values the three-quarter mark falls at six entries, and the overflow counter saturates at 7 after only a handful of dropped reports. The age limit in both forms, programmed (10 cycles) and default (40 cycles), can be checked at its exact cycle boundary. A 16-bit address width keeps the table of push and pop vectors readable while still giving distinct head values to follow the queue order.

// File: rtl/mel_pkg.sv
package mel_pkg;

  localparam int unsigned DEF_DEPTH   = 16;
  localparam int unsigned DEF_CLASS_W = 3;
  localparam int unsigned DEF_ADDR_W  = 40;
  localparam int unsigned DEF_BANK_W  = 4;
  localparam int unsigned DEF_DEV_W   = 4;
  localparam int unsigned DEF_OVF_W   = 8;
  localparam int unsigned DEF_AGE_W   = 32;
  // one second at a 100 MHz clock
  localparam int unsigned DEF_AGE_CYC = 100_000_000;

  // fill level at which software is asked to drain
  function automatic int unsigned fill_mark(input int unsigned depth);
    return (depth * 3) / 4;
  endfunction

endpackage

// File: rtl/mel_fifo.sv
module mel_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  // storage array without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      unique case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data = store[rd_ptr];
  assign count   = cnt_q;
  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);

endmodule

// File: rtl/mel_age_timer.sv
module mel_age_timer #(
  parameter int unsigned AGE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  output logic [AGE_W-1:0] age
);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      age_q <= '0;
    end else if (run && (age_q != {AGE_W{1'b1}})) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign age = age_q;

endmodule

// File: rtl/mel_irq_ctrl.sv
module mel_irq_ctrl #(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned AGE_W       = 32,
  parameter int unsigned AGE_DEFAULT = 100_000_000,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] level,
  input  logic             empty,
  input  logic [AGE_W-1:0] age,
  input  logic [AGE_W-1:0] cfg_age_limit,
  input  logic             sev_in,
  input  logic             sev_out,
  output logic             irq
);

  localparam logic [CNT_W-1:0] MARK     = CNT_W'(mel_pkg::fill_mark(DEPTH));
  localparam logic [AGE_W-1:0] AGE_DFLT = AGE_W'(AGE_DEFAULT);

  logic [CNT_W-1:0] sev_cnt;
  logic [AGE_W-1:0] limit;
  logic             fill_hit, sev_hit, age_hit;
  logic             irq_q;

  // number of stored entries flagged severe at accept time
  always_ff @(posedge clk) begin
    if (rst) begin
      sev_cnt <= '0;
    end else begin
      unique case ({sev_in, sev_out})
        2'b10:   sev_cnt <= sev_cnt + 1'b1;
        2'b01:   sev_cnt <= sev_cnt - 1'b1;
        default: sev_cnt <= sev_cnt;
      endcase
    end
  end

  always_comb begin
    limit    = (cfg_age_limit == '0) ? AGE_DFLT : cfg_age_limit;
    fill_hit = (level >= MARK);
    sev_hit  = (sev_cnt != '0);
    age_hit  = !empty && (age >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= fill_hit || sev_hit || age_hit;
  end

  assign irq = irq_q;

endmodule

// File: rtl/mem_err_log.sv
module mem_err_log #(
  parameter int unsigned DEPTH       = mel_pkg::DEF_DEPTH,
  parameter int unsigned CLASS_W     = mel_pkg::DEF_CLASS_W,
  parameter int unsigned ADDR_W      = mel_pkg::DEF_ADDR_W,
  parameter int unsigned BANK_W      = mel_pkg::DEF_BANK_W,
  parameter int unsigned DEV_W       = mel_pkg::DEF_DEV_W,
  parameter int unsigned OVF_W       = mel_pkg::DEF_OVF_W,
  parameter int unsigned AGE_W       = mel_pkg::DEF_AGE_W,
  parameter int unsigned AGE_DEFAULT = mel_pkg::DEF_AGE_CYC,
  localparam int unsigned NCLASS = 1 << CLASS_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rpt_valid,
  input  logic [CLASS_W-1:0] rpt_class,
  input  logic              rpt_uncorr,
  input  logic              rpt_async,
  input  logic [ADDR_W-1:0] rpt_addr,
  input  logic [BANK_W-1:0] rpt_bank,
  input  logic [DEV_W-1:0]  rpt_dev,
  input  logic              pop,
  input  logic [NCLASS-1:0] cfg_severe_mask,
  input  logic [AGE_W-1:0]  cfg_age_limit,
  output logic              irq,
  output logic              sync_fault,
  output logic [OVF_W-1:0]  ovf_count,
  output logic [CNT_W-1:0]  level,
  output logic              head_valid,
  output logic [CLASS_W-1:0] head_class,
  output logic              head_uncorr,
  output logic              head_async,
  output logic [ADDR_W-1:0] head_addr,
  output logic [BANK_W-1:0] head_bank,
  output logic [DEV_W-1:0]  head_dev
);

  // entry layout, low to high: addr, dev, bank, async, uncorr, class, severe
  localparam int unsigned DEV_LO   = ADDR_W;
  localparam int unsigned BANK_LO  = DEV_LO + DEV_W;
  localparam int unsigned ASY_BIT  = BANK_LO + BANK_W;
  localparam int unsigned UNC_BIT  = ASY_BIT + 1;
  localparam int unsigned CLS_LO   = UNC_BIT + 1;
  localparam int unsigned SEV_BIT  = CLS_LO + CLASS_W;
  localparam int unsigned ENTRY_W  = SEV_BIT + 1;

  logic [ENTRY_W-1:0] wr_entry, rd_entry;
  logic [CNT_W-1:0]   fifo_cnt;
  logic               fifo_full, fifo_empty;
  logic               pop_eff, accept, drop, wr_sev;
  logic [AGE_W-1:0]   head_age;
  logic [OVF_W-1:0]   ovf_q;
  logic               fault_q;

  always_comb begin
    pop_eff  = pop && !fifo_empty;
    accept   = rpt_valid && (!fifo_full || pop_eff);
    drop     = rpt_valid && !accept;
    wr_sev   = cfg_severe_mask[rpt_class];
    wr_entry = {wr_sev, rpt_class, rpt_uncorr, rpt_async,
                rpt_bank, rpt_dev, rpt_addr};
  end

  mel_fifo #(
    .DEPTH (DEPTH),
    .WIDTH (ENTRY_W)
  ) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (accept),
    .wr_data (wr_entry),
    .rd_en   (pop_eff),
    .rd_data (rd_entry),
    .count   (fifo_cnt),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  // a new head appears on a write into an empty queue or on any pop
  mel_age_timer #(
    .AGE_W (AGE_W)
  ) u_age (
    .clk     (clk),
    .rst     (rst),
    .restart ((accept && fifo_empty) || pop_eff),
    .run     (!fifo_empty),
    .age     (head_age)
  );

  mel_irq_ctrl #(
    .DEPTH       (DEPTH),
    .AGE_W       (AGE_W),
    .AGE_DEFAULT (AGE_DEFAULT)
  ) u_irq (
    .clk           (clk),
    .rst           (rst),
    .level         (fifo_cnt),
    .empty         (fifo_empty),
    .age           (head_age),
    .cfg_age_limit (cfg_age_limit),
    .sev_in        (accept && wr_sev),
    .sev_out       (pop_eff && rd_entry[SEV_BIT]),
    .irq           (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (drop && (ovf_q != {OVF_W{1'b1}})) ovf_q <= ovf_q + 1'b1;
      fault_q <= rpt_valid && rpt_uncorr && !rpt_async;
    end
  end

  assign sync_fault  = fault_q;
  assign ovf_count   = ovf_q;
  assign level       = fifo_cnt;
  assign head_valid  = !fifo_empty;
  assign head_class  = rd_entry[CLS_LO +: CLASS_W];
  assign head_uncorr = rd_entry[UNC_BIT];
  assign head_async  = rd_entry[ASY_BIT];
  assign head_bank   = rd_entry[BANK_LO +: BANK_W];
  assign head_dev    = rd_entry[DEV_LO +: DEV_W];
  assign head_addr   = rd_entry[ADDR_W-1:0];

endmodule

// File: rtl/mel_log_chk.sv
module mel_log_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned OVF_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rpt_valid,
  input logic             rpt_async,
  input logic             pop,
  input logic [CNT_W-1:0] level,
  input logic [OVF_W-1:0] ovf_count,
  input logic             irq,
  input logic             sync_fault,
  input logic             head_valid
);

  localparam int unsigned MARK = mel_pkg::fill_mark(DEPTH);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(level) <= DEPTH));

  // R1
  head_flag_chk: assert property (@(posedge clk) disable iff (rst)
    head_valid == (level != '0));

  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && pop && !rpt_valid) |=> (level == '0));

  // R3
  async_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_async) |=> !sync_fault);

  // R4
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(level) == DEPTH && rpt_valid && !pop) |=> (int'(level) == DEPTH));

  // R4
  ovf_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |=> (ovf_count >= $past(ovf_count)));

  // R6
  fill_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(level) >= MARK) |=> irq);

endmodule

bind mem_err_log mel_log_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W),
  .OVF_W (OVF_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .rpt_valid  (rpt_valid),
  .rpt_async  (rpt_async),
  .pop        (pop),
  .level      (level),
  .ovf_count  (ovf_count),
  .irq        (irq),
  .sync_fault (sync_fault),
  .head_valid (head_valid)
);

// File: tb/mem_err_log_test.sv
module mem_err_log_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH   = 8;
  localparam int CLASS_W = 3;
  localparam int ADDR_W  = 16;
  localparam int BANK_W  = 3;
  localparam int DEV_W   = 2;
  localparam int OVF_W   = 3;
  localparam int AGE_W   = 16;
  localparam int AGE_DEF = 40;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rpt_valid = 1'b0;
  logic [CLASS_W-1:0] rpt_class = '0;
  logic rpt_uncorr = 1'b0;
  logic rpt_async = 1'b0;
  logic [ADDR_W-1:0] rpt_addr = '0;
  logic [BANK_W-1:0] rpt_bank = '0;
  logic [DEV_W-1:0] rpt_dev = '0;
  logic pop = 1'b0;
  logic [(1<<CLASS_W)-1:0] cfg_severe_mask = '0;
  logic [AGE_W-1:0] cfg_age_limit = 16'd1000;
  logic irq, sync_fault, head_valid, head_uncorr, head_async;
  logic [OVF_W-1:0] ovf_count;
  logic [CNT_W-1:0] level;
  logic [CLASS_W-1:0] head_class;
  logic [ADDR_W-1:0] head_addr;
  logic [BANK_W-1:0] head_bank;
  logic [DEV_W-1:0] head_dev;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_err_log #(
    .DEPTH(DEPTH), .CLASS_W(CLASS_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
    .DEV_W(DEV_W), .OVF_W(OVF_W), .AGE_W(AGE_W), .AGE_DEFAULT(AGE_DEF)
  ) uut (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_class(rpt_class),
    .rpt_uncorr(rpt_uncorr), .rpt_async(rpt_async), .rpt_addr(rpt_addr),
    .rpt_bank(rpt_bank), .rpt_dev(rpt_dev), .pop(pop),
    .cfg_severe_mask(cfg_severe_mask), .cfg_age_limit(cfg_age_limit),
    .irq(irq), .sync_fault(sync_fault), .ovf_count(ovf_count), .level(level),
    .head_valid(head_valid), .head_class(head_class), .head_uncorr(head_uncorr),
    .head_async(head_async), .head_addr(head_addr), .head_bank(head_bank),
    .head_dev(head_dev)
  );

  typedef struct packed {
    logic        push;
    logic        pp;
    logic        unc;
    logic        asy;
    logic [15:0] addr;
    logic [3:0]  cnt;
    logic [15:0] head;
    logic        fault;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0101, 4'd1, 16'h0101, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 16'h0202, 4'd2, 16'h0101, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 16'h0303, 4'd3, 16'h0101, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd2, 16'h0202, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0404, 4'd2, 16'h0303, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1, 16'h0404, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd0, 16'h0000, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd0, 16'h0000, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'h0505, 4'd1, 16'h0505, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic cyc(input logic v, input logic p, input logic [CLASS_W-1:0] c,
                     input logic u, input logic a, input logic [ADDR_W-1:0] ad);
    rpt_valid = v; pop = p; rpt_class = c; rpt_uncorr = u; rpt_async = a;
    rpt_addr = ad; rpt_bank = '0; rpt_dev = '0;
    tick();
    rpt_valid = 1'b0; pop = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ticks(2);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11", "level", 32'(level), 0);
    chk("R11", "ovf_count", 32'(ovf_count), 0);
    chk("R11", "irq", 32'(irq), 0);
    chk("R11", "sync_fault", 32'(sync_fault), 0);
    chk("R11", "head_valid", 32'(head_valid), 0);

    // R1 R2 R3 vector walk
    foreach (VECS[i]) begin
      cyc(VECS[i].push, VECS[i].pp, 3'd0, VECS[i].unc, VECS[i].asy, VECS[i].addr);
      chk("R1", "level", 32'(level), 32'(VECS[i].cnt));
      if (VECS[i].cnt != 0) chk("R2", "head_addr", 32'(head_addr), 32'(VECS[i].head));
      chk("R3", "sync_fault", 32'(sync_fault), 32'(VECS[i].fault));
    end
    tick();
    chk("R3", "fault one cycle", 32'(sync_fault), 0);

    // R1 head fields
    do_reset();
    rpt_valid = 1; rpt_class = 3'd6; rpt_uncorr = 1; rpt_async = 1;
    rpt_addr = 16'hBEEF; rpt_bank = 3'd5; rpt_dev = 2'd2;
    tick();
    rpt_valid = 0;
    chk("R1", "head_class", 32'(head_class), 6);
    chk("R1", "head_uncorr", 32'(head_uncorr), 1);
    chk("R1", "head_async", 32'(head_async), 1);
    chk("R1", "head_bank", 32'(head_bank), 5);
    chk("R1", "head_dev", 32'(head_dev), 2);
    chk("R1", "head_addr", 32'(head_addr), 32'hBEEF);
    chk("R1", "head_valid", 32'(head_valid), 1);
    do_reset();
    chk("R11", "level after reset", 32'(level), 0);

    // R6 R10 fill mark
    for (int i = 0; i < 5; i++) cyc(1, 0, 3'd0, 0, 0, 16'(16'h20 + i));
    tick();
    chk("R6", "irq below mark", 32'(irq), 0);
    cyc(1, 0, 3'd0, 0, 0, 16'h25);
    chk("R6", "irq lag", 32'(irq), 0);
    tick();
    chk("R6", "irq at mark", 32'(irq), 1);
    cyc(0, 1, 3'd0, 0, 0, 16'h0);
    chk("R10", "irq held one cycle", 32'(irq), 1);
    tick();
    chk("R10", "irq cleared", 32'(irq), 0);

    // R4 R5 overflow
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, 0, 3'd0, 0, 0, 16'(16'h10 + i));
    for (int i = 0; i < 3; i++) cyc(1, 0, 3'd0, 0, 0, 16'hEE);
    chk("R4", "ovf_count", 32'(ovf_count), 3);
    chk("R4", "level full", 32'(level), 8);
    chk("R4", "head kept", 32'(head_addr), 32'h10);
    for (int i = 0; i < 5; i++) cyc(1, 0, 3'd0, 0, 0, 16'hEE);
    chk("R4", "ovf saturates", 32'(ovf_count), 7);
    cyc(1, 1, 3'd0, 0, 0, 16'h77);
    chk("R5", "level", 32'(level), 8);
    chk("R5", "ovf unchanged", 32'(ovf_count), 7);
    chk("R5", "head", 32'(head_addr), 32'h11);
    for (int i = 0; i < 7; i++) cyc(0, 1, 3'd0, 0, 0, 16'h0);
    chk("R5", "accepted entry at tail", 32'(head_addr), 32'h77);

    // R7 severe class
    do_reset();
    cfg_severe_mask = 8'b0010_0000;
    cyc(1, 0, 3'd2, 0, 0, 16'h31);
    tick();
    chk("R7", "non-severe no irq", 32'(irq), 0);
    cyc(1, 0, 3'd5, 0, 0, 16'h32);
    tick();
    chk("R7", "severe irq", 32'(irq), 1);
    cyc(0, 1, 3'd0, 0, 0, 16'h0);
    tick();
    chk("R7", "severe still stored", 32'(irq), 1);
    cyc(0, 1, 3'd0, 0, 0, 16'h0);
    tick();
    chk("R7", "severe drained", 32'(irq), 0);
    cfg_severe_mask = '0;

    // R8 age limit, restart and stop
    do_reset();
    cfg_age_limit = 16'd10;
    cyc(1, 0, 3'd0, 0, 0, 16'h41);
    ticks(9);
    chk("R8", "age 9 reflected", 32'(irq), 0);
    tick();
    chk("R8", "age 10 not yet reflected", 32'(irq), 0);
    tick();
    chk("R8", "age limit irq", 32'(irq), 1);
    cyc(1, 0, 3'd0, 0, 0, 16'h42);
    cyc(0, 1, 3'd0, 0, 0, 16'h0);
    tick();
    chk("R8", "restart clears irq", 32'(irq), 0);
    ticks(8);
    chk("R8", "new head age 9 reflected", 32'(irq), 0);
    tick();
    chk("R8", "new head age 10 not yet reflected", 32'(irq), 0);
    tick();
    chk("R8", "new head age irq", 32'(irq), 1);
    cyc(0, 1, 3'd0, 0, 0, 16'h0);
    ticks(20);
    chk("R8", "empty stops age", 32'(irq), 0);

    // R9 default limit
    do_reset();
    cfg_age_limit = '0;
    cyc(1, 0, 3'd0, 0, 0, 16'h51);
    ticks(40);
    chk("R9", "before default limit", 32'(irq), 0);
    tick();
    chk("R9", "default limit irq", 32'(irq), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule